// File: doc/BRIEF.md
# Frequency Synthesizer Programming Interface

This block is the control front end of an integer-N frequency synthesizer. It produces the main-counter, reference-counter and swallow-counter values, a prescaler enable, a power-down bit and a byte of enhancement controls. It takes them from one of three sources, chosen by two mode pins. The serial source is a clock/data shift port that fills either a primary shift register or an enhancement shift register. The parallel source is a byte-wide bus with separate load strobes. The direct source is a set of configuration pins read straight through.

All pins, including the serial clock and the strobes, are resynchronized to the system clock. Edges are then detected on the synchronized copies, so the whole block runs on one clock. Serial data goes into holding registers only on commit edges, so the outputs never show a partly shifted word. The enhancement byte drives its outputs only while an active-low enable pin is low.

Top module: `synth_prog_if`

## Requirements
- R1: While `rst_n` is low, every counter output, `pre_en_o`, `pwr_dn_o` and `enh_ctrl_o` read zero.
- R2: In serial mode with `enh_wr_i` low, each synchronized rising edge of `sclk_i` shifts `sdata_i` into the primary shift register, first bit most significant. A rising edge of `pri_wr_i` copies the shift register to the outputs. The 20-bit word is arranged as bit 19 = prescaler enable, bits 18:10 = main counter, bits 9:4 = reference counter, bits 3:0 = swallow counter.
- R3: Primary outputs do not change while bits are shifted in serial mode until `pri_wr_i` rises.
- R4: In serial mode with `enh_wr_i` high, serial clock edges fill the 8-bit enhancement shift register, first bit most significant. The enhancement outputs change only when `enh_wr_i` falls, and then take the shifted byte. Enhancement shifting leaves the primary shift register untouched.
- R5: `enh_ctrl_o` shows the committed enhancement byte only while `enh_en_n_i` is low; otherwise it reads zero. `pwr_dn_o` equals bit 0 of `enh_ctrl_o`.
- R6: In parallel mode, rising edges of the strobes load bus bits into the primary fields. `p_wr_i[0]` loads main[7:0] from bus[7:0]. `p_wr_i[1]` loads prescaler enable from bus[7], main[8] from bus[6] and reference[5:0] from bus[5:0]. `p_wr_i[2]` loads swallow[3:0] from bus[3:0].
- R7: In parallel mode, a rising edge of `enh_wr_i` loads the enhancement byte from the bus.
- R8: In direct mode, the outputs follow `dir_cfg_i` in the R2 layout, except that main[8:7] and reference[5:4] are forced to zero. Leaving direct mode brings back the held values unchanged.
- R9: `mode_b_i`=1 selects direct mode whatever `mode_s_i` is. Otherwise `mode_s_i`=1 selects serial mode and 0 selects parallel mode. Strobes that belong to another mode are ignored.
- R10: A primary commit after fewer than 20 new bits copies the shift register as it stands: the earlier contents moved up by the number of new bits, with the new bits below them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_b_i | input | 1 | Direct-mode select |
| mode_s_i | input | 1 | Serial (1) / parallel (0) select |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data |
| pri_wr_i | input | 1 | Primary commit strobe (rising edge) |
| enh_wr_i | input | 1 | Enhancement select / commit strobe |
| enh_en_n_i | input | 1 | Active-low enhancement enable |
| p_bus_i | input | 8 | Parallel data bus |
| p_wr_i | input | 3 | Parallel section load strobes |
| dir_cfg_i | input | 20 | Direct configuration word |
| main_cnt_o | output | 9 | Active main-counter value |
| ref_cnt_o | output | 6 | Active reference-counter value |
| swl_cnt_o | output | 4 | Active swallow-counter value |
| pre_en_o | output | 1 | Prescaler enable |
| pwr_dn_o | output | 1 | Power-down |
| enh_ctrl_o | output | 8 | Gated enhancement control bits |

## Verification
The bench keeps the default field widths, which give the 20-bit primary word and the byte-wide bus. It overrides the synchronizer depth to three stages, so every strobe and data bit goes through a longer chain than the default. With the deeper chain, the bench can show that data and strobes stay aligned when they pass through the same depth. It can also show that commits still land only on detected edges, and that switching between direct and held values does not disturb the held registers.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

   typedef enum logic [1:0] {
      MODE_PAR = 2'd0,
      MODE_SER = 2'd1,
      MODE_DIR = 2'd2
   } prog_mode_e;

   function automatic prog_mode_e decode_mode(input logic sel_b, input logic sel_s);
      if (sel_b)      return MODE_DIR;
      else if (sel_s) return MODE_SER;
      else            return MODE_PAR;
   endfunction

endpackage

// File: rtl/synth_prog_sync.sv
module synth_prog_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("synth_prog_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/synth_prog_shift.sv
module synth_prog_shift #(
   parameter int PRI_W = 20,
   parameter int ENH_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             sel_enh,
   input  logic             din,
   output logic [PRI_W-1:0] pri_sr,
   output logic [ENH_W-1:0] enh_sr
);

   generate
      if (PRI_W < 2 || ENH_W < 2) begin : g_bad_width
         $error("synth_prog_shift: shift registers need at least two bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_sr <= '0;
         enh_sr <= '0;
      end else if (shift_en) begin
         if (sel_enh) enh_sr <= {enh_sr[ENH_W-2:0], din};
         else         pri_sr <= {pri_sr[PRI_W-2:0], din};
      end
   end

endmodule

// File: rtl/synth_prog_hold.sv
module synth_prog_hold #(
   parameter int MAIN_W = 9,
   parameter int REF_W  = 6,
   parameter int SWL_W  = 4,
   parameter int ENH_W  = 8,
   parameter int BUS_W  = 8,
   localparam int PRI_W  = 1 + MAIN_W + REF_W + SWL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pri_load,
   input  logic [PRI_W-1:0] pri_sr,
   input  logic             enh_ser_load,
   input  logic [ENH_W-1:0] enh_sr,
   input  logic             enh_par_load,
   input  logic [2:0]       par_ld,
   input  logic [BUS_W-1:0] bus,
   output logic [PRI_W-1:0] pri_hold,
   output logic [ENH_W-1:0] enh_buf
);

   localparam int REF_LO  = SWL_W;
   localparam int MAIN_LO = SWL_W + REF_W;
   localparam int PRE_POS = MAIN_LO + MAIN_W;
   localparam int HI_W    = MAIN_W - BUS_W;

   generate
      if (HI_W < 1) begin : g_bad_main
         $error("synth_prog_hold: main counter must be wider than the bus");
      end
      if (1 + HI_W + REF_W != BUS_W) begin : g_bad_pack
         $error("synth_prog_hold: prescaler, main high and reference must fill one bus word");
      end
      if (SWL_W > BUS_W || ENH_W != BUS_W) begin : g_bad_bus
         $error("synth_prog_hold: swallow and enhancement must fit the bus");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_hold <= '0;
      end else if (pri_load) begin
         pri_hold <= pri_sr;
      end else begin
         if (par_ld[0]) pri_hold[MAIN_LO +: BUS_W] <= bus;
         if (par_ld[1]) begin
            pri_hold[PRE_POS]                <= bus[BUS_W-1];
            pri_hold[MAIN_LO+BUS_W +: HI_W]  <= bus[REF_W +: HI_W];
            pri_hold[REF_LO +: REF_W]        <= bus[REF_W-1:0];
         end
         if (par_ld[2]) pri_hold[SWL_W-1:0] <= bus[SWL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            enh_buf <= '0;
      else if (enh_ser_load) enh_buf <= enh_sr;
      else if (enh_par_load) enh_buf <= bus[ENH_W-1:0];
   end

endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if #(
   parameter int MAIN_W      = 9,
   parameter int REF_W       = 6,
   parameter int SWL_W       = 4,
   parameter int ENH_W       = 8,
   parameter int BUS_W       = 8,
   parameter int DIR_ZERO    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int PD_BIT      = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          mode_b_i,
   input  logic                          mode_s_i,
   input  logic                          sclk_i,
   input  logic                          sdata_i,
   input  logic                          pri_wr_i,
   input  logic                          enh_wr_i,
   input  logic                          enh_en_n_i,
   input  logic [BUS_W-1:0]              p_bus_i,
   input  logic [2:0]                    p_wr_i,
   input  logic [MAIN_W+REF_W+SWL_W:0]   dir_cfg_i,
   output logic [MAIN_W-1:0]             main_cnt_o,
   output logic [REF_W-1:0]              ref_cnt_o,
   output logic [SWL_W-1:0]              swl_cnt_o,
   output logic                          pre_en_o,
   output logic                          pwr_dn_o,
   output logic [ENH_W-1:0]              enh_ctrl_o
);
   import synth_prog_pkg::*;

   localparam int PRI_W   = 1 + MAIN_W + REF_W + SWL_W;
   localparam int REF_LO  = SWL_W;
   localparam int MAIN_LO = SWL_W + REF_W;
   localparam int PRE_POS = MAIN_LO + MAIN_W;
   localparam int CTL_N   = 10;
   localparam int SYNC_W  = CTL_N + BUS_W + PRI_W;

   generate
      if (DIR_ZERO > MAIN_W || DIR_ZERO > REF_W) begin : g_bad_zero
         $error("synth_prog_if: DIR_ZERO exceeds a counter width");
      end
      if (PD_BIT >= ENH_W) begin : g_bad_pd
         $error("synth_prog_if: PD_BIT outside enhancement byte");
      end
   endgenerate

   // resynchronize every pin with the same depth so data and strobes stay aligned
   logic [SYNC_W-1:0] sync_q;
   synth_prog_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dir_cfg_i, p_bus_i, mode_s_i, mode_b_i, p_wr_i,
               enh_en_n_i, enh_wr_i, pri_wr_i, sdata_i, sclk_i}),
      .q     (sync_q)
   );

   logic             sclk_s, sdata_s, pri_wr_s, enh_sel, enh_n_s, mode_b_s, mode_s_s;
   logic [2:0]       p_wr_s;
   logic [BUS_W-1:0] bus_s;
   logic [PRI_W-1:0] dir_s;

   assign sclk_s   = sync_q[0];
   assign sdata_s  = sync_q[1];
   assign pri_wr_s = sync_q[2];
   assign enh_sel  = sync_q[3];
   assign enh_n_s  = sync_q[4];
   assign p_wr_s   = sync_q[7:5];
   assign mode_b_s = sync_q[8];
   assign mode_s_s = sync_q[9];
   assign bus_s    = sync_q[CTL_N +: BUS_W];
   assign dir_s    = sync_q[CTL_N+BUS_W +: PRI_W];

   // edge detection on synchronized strobes
   logic [5:0] edge_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) edge_prev <= '0;
      else        edge_prev <= {p_wr_s, enh_sel, pri_wr_s, sclk_s};
   end

   logic       sclk_rise, pri_rise, enh_rise, enh_fall;
   logic [2:0] p_rise;
   assign sclk_rise = sclk_s   & ~edge_prev[0];
   assign pri_rise  = pri_wr_s & ~edge_prev[1];
   assign enh_rise  = enh_sel  & ~edge_prev[2];
   assign enh_fall  = ~enh_sel &  edge_prev[2];
   assign p_rise    = p_wr_s   & ~edge_prev[5:3];

   prog_mode_e mode;
   logic       is_ser, is_par, is_dir;
   assign mode   = decode_mode(mode_b_s, mode_s_s);
   assign is_ser = (mode == MODE_SER);
   assign is_par = (mode == MODE_PAR);
   assign is_dir = (mode == MODE_DIR);

   logic pri_commit, enh_ser_load, enh_par_load, enh_load;
   assign pri_commit   = pri_rise & is_ser;
   assign enh_ser_load = enh_fall & is_ser;
   assign enh_par_load = enh_rise & is_par;
   assign enh_load     = enh_ser_load | enh_par_load;

   logic [PRI_W-1:0] pri_sr;
   logic [ENH_W-1:0] enh_sr;
   synth_prog_shift #(.PRI_W(PRI_W), .ENH_W(ENH_W)) shift_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sclk_rise & is_ser),
      .sel_enh  (enh_sel),
      .din      (sdata_s),
      .pri_sr   (pri_sr),
      .enh_sr   (enh_sr)
   );

   logic [PRI_W-1:0] pri_hold;
   logic [ENH_W-1:0] enh_buf;
   synth_prog_hold #(
      .MAIN_W (MAIN_W), .REF_W (REF_W), .SWL_W (SWL_W),
      .ENH_W  (ENH_W),  .BUS_W (BUS_W)
   ) hold_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .pri_load     (pri_commit),
      .pri_sr       (pri_sr),
      .enh_ser_load (enh_ser_load),
      .enh_sr       (enh_sr),
      .enh_par_load (enh_par_load),
      .par_ld       (p_rise & {3{is_par}}),
      .bus          (bus_s),
      .pri_hold     (pri_hold),
      .enh_buf      (enh_buf)
   );

   // direct word with the top counter bits tied low
   logic [PRI_W-1:0] dir_word;
   always_comb begin
      dir_word = dir_s;
      dir_word[PRE_POS-1 -: DIR_ZERO] = '0;
      dir_word[MAIN_LO-1 -: DIR_ZERO] = '0;
   end

   logic [PRI_W-1:0] active;
   assign active     = is_dir ? dir_word : pri_hold;
   assign pre_en_o   = active[PRE_POS];
   assign main_cnt_o = active[MAIN_LO +: MAIN_W];
   assign ref_cnt_o  = active[REF_LO +: REF_W];
   assign swl_cnt_o  = active[SWL_W-1:0];
   assign enh_ctrl_o = enh_n_s ? '0 : enh_buf;
   assign pwr_dn_o   = enh_ctrl_o[PD_BIT];

endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
   parameter int MAIN_W   = 9,
   parameter int REF_W    = 6,
   parameter int SWL_W    = 4,
   parameter int ENH_W    = 8,
   parameter int DIR_ZERO = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              is_ser,
   input logic              is_par,
   input logic              is_dir,
   input logic              sclk_rise,
   input logic              enh_sel,
   input logic              sdata_s,
   input logic              pri_commit,
   input logic              enh_load,
   input logic              enh_n_s,
   input logic              pri_sr0,
   input logic              enh_sr0,
   input logic [MAIN_W-1:0] main_cnt_o,
   input logic [REF_W-1:0]  ref_cnt_o,
   input logic [SWL_W-1:0]  swl_cnt_o,
   input logic              pre_en_o,
   input logic              pwr_dn_o,
   input logic [ENH_W-1:0]  enh_ctrl_o,
   input logic [ENH_W-1:0]  enh_buf
);

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_zero: assert (main_cnt_o == '0 && ref_cnt_o == '0 && swl_cnt_o == '0
                                  && !pre_en_o && !pwr_dn_o && enh_ctrl_o == '0);
      end
   end

   a_r2_pri_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise && is_ser && !enh_sel) |=> (pri_sr0 == $past(sdata_s)));

   a_r4_enh_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise && is_ser && enh_sel) |=> (enh_sr0 == $past(sdata_s)));

   a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ser && !pri_commit) |=>
      (!is_ser || $stable({pre_en_o, main_cnt_o, ref_cnt_o, swl_cnt_o})));

   a_r4_enh_buf_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !enh_load |=> $stable(enh_buf));

   a_r5_enh_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (enh_ctrl_o != '0) |-> !enh_n_s);

   a_r8_direct_zero: assert property (@(posedge clk) disable iff (!rst_n)
      is_dir |-> (main_cnt_o[MAIN_W-1 -: DIR_ZERO] == '0 && ref_cnt_o[REF_W-1 -: DIR_ZERO] == '0));

   a_r9_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({is_ser, is_par, is_dir}));

endmodule

bind synth_prog_if synth_prog_if_chk #(
   .MAIN_W (MAIN_W), .REF_W (REF_W), .SWL_W (SWL_W),
   .ENH_W  (ENH_W),  .DIR_ZERO (DIR_ZERO)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .is_ser     (is_ser),
   .is_par     (is_par),
   .is_dir     (is_dir),
   .sclk_rise  (sclk_rise),
   .enh_sel    (enh_sel),
   .sdata_s    (sdata_s),
   .pri_commit (pri_commit),
   .enh_load   (enh_load),
   .enh_n_s    (enh_n_s),
   .pri_sr0    (pri_sr[0]),
   .enh_sr0    (enh_sr[0]),
   .main_cnt_o (main_cnt_o),
   .ref_cnt_o  (ref_cnt_o),
   .swl_cnt_o  (swl_cnt_o),
   .pre_en_o   (pre_en_o),
   .pwr_dn_o   (pwr_dn_o),
   .enh_ctrl_o (enh_ctrl_o),
   .enh_buf    (enh_buf)
);

// File: tb/synth_prog_if_tb_top.sv
module synth_prog_if_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_b = 1'b0, mode_s = 1'b1;
   logic        sclk = 1'b0, sdata = 1'b0, pri_wr = 1'b0, enh_wr = 1'b0, enh_n = 1'b0;
   logic [7:0]  p_bus = '0;
   logic [2:0]  p_wr = '0;
   logic [19:0] dir_cfg = '0;
   logic [8:0]  main_cnt;
   logic [5:0]  ref_cnt;
   logic [3:0]  swl_cnt;
   logic        pre_en, pwr_dn;
   logic [7:0]  enh_ctrl;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   synth_prog_if #(.SYNC_STAGES(3)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_b_i   (mode_b),
      .mode_s_i   (mode_s),
      .sclk_i     (sclk),
      .sdata_i    (sdata),
      .pri_wr_i   (pri_wr),
      .enh_wr_i   (enh_wr),
      .enh_en_n_i (enh_n),
      .p_bus_i    (p_bus),
      .p_wr_i     (p_wr),
      .dir_cfg_i  (dir_cfg),
      .main_cnt_o (main_cnt),
      .ref_cnt_o  (ref_cnt),
      .swl_cnt_o  (swl_cnt),
      .pre_en_o   (pre_en),
      .pwr_dn_o   (pwr_dn),
      .enh_ctrl_o (enh_ctrl)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [19:0] got_word();
      return {pre_en, main_cnt, ref_cnt, swl_cnt};
   endfunction

   task automatic check_word(input string req, input logic [19:0] exp);
      checks++;
      if (got_word() !== exp) begin
         fails++;
         $display("FAIL %s: word actual=%05h expected=%05h", req, got_word(), exp);
      end
   endtask

   task automatic check_enh(input string req, input logic [7:0] exp);
      checks++;
      if (enh_ctrl !== exp || pwr_dn !== exp[0]) begin
         fails++;
         $display("FAIL %s: enh actual=%02h/pd%0b expected=%02h/pd%0b",
                  req, enh_ctrl, pwr_dn, exp, exp[0]);
      end
   endtask

   task automatic ser_bit(input logic b);
      sdata = b; tick(4);
      sclk = 1'b1; tick(4);
      sclk = 1'b0; tick(4);
   endtask

   task automatic ser_bits(input logic [19:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) ser_bit(w[i]);
   endtask

   task automatic pulse_pri();
      pri_wr = 1'b1; tick(SETTLE); pri_wr = 1'b0; tick(SETTLE);
   endtask

   task automatic pulse_par(input int idx, input logic [7:0] v);
      p_bus = v; tick(SETTLE);
      p_wr[idx] = 1'b1; tick(SETTLE);
      p_wr[idx] = 1'b0; tick(SETTLE);
   endtask

   function automatic logic [19:0] direct_view(input logic [19:0] w);
      logic [19:0] r = w;
      r[18:17] = 2'b00;   // main[8:7]
      r[9:8]   = 2'b00;   // ref[5:4]
      return r;
   endfunction

   task automatic t_reset();
      rst_n = 1'b0; tick(4);
      check_word("R1", 20'h0);
      check_enh("R1", 8'h00);
      rst_n = 1'b1; tick(SETTLE);
   endtask

   task automatic t_serial_primary(input logic [19:0] w, input logic [19:0] prev);
      ser_bits(w, 20);
      check_word("R3", prev);
      pulse_pri();
      check_word("R2", w);
   endtask

   task automatic t_serial_enh(input logic [7:0] e, input logic [19:0] pri_now);
      enh_wr = 1'b1; tick(SETTLE);
      ser_bits({12'h0, e}, 8);
      check_enh("R4", 8'h00);
      enh_wr = 1'b0; tick(SETTLE);
      check_enh("R4", e);
      pulse_pri();
      check_word("R4", pri_now);   // primary shift register untouched
   endtask

   task automatic t_enh_gate(input logic [7:0] e);
      enh_n = 1'b1; tick(SETTLE);
      check_enh("R5", 8'h00);
      enh_n = 1'b0; tick(SETTLE);
      check_enh("R5", e);
   endtask

   task automatic t_short_commit(input logic [19:0] prev);
      ser_bits(20'h9, 4);
      pulse_pri();
      check_word("R10", {prev[15:0], 4'h9});
   endtask

   task automatic t_mode_ignore(input logic [19:0] held);
      pulse_par(0, 8'hFF);
      pulse_par(1, 8'hFF);
      pulse_par(2, 8'hFF);
      check_word("R9", held);
      mode_s = 1'b0; tick(SETTLE);
      ser_bits(20'h0, 3);
      pulse_pri();
      check_word("R9", held);
   endtask

   task automatic t_parallel(input logic [19:0] held);
      logic [19:0] exp = held;
      pulse_par(0, 8'h3C);
      exp[17:10] = 8'h3C;
      check_word("R6", exp);
      pulse_par(1, 8'hEA);
      exp[19] = 1'b1; exp[18] = 1'b1; exp[9:4] = 6'h2A;
      check_word("R6", exp);
      pulse_par(2, 8'hF6);
      exp[3:0] = 4'h6;
      check_word("R6", exp);
      p_bus = 8'h5A; tick(SETTLE);
      enh_wr = 1'b1; tick(SETTLE);
      check_enh("R7", 8'h5A);
      enh_wr = 1'b0; tick(SETTLE);
      check_enh("R7", 8'h5A);
   endtask

   task automatic t_direct(input logic [19:0] held);
      dir_cfg = 20'hFFFFF; mode_b = 1'b1; mode_s = 1'b1; tick(SETTLE);
      check_word("R8", direct_view(20'hFFFFF));
      mode_s = 1'b0; dir_cfg = 20'h12345; tick(SETTLE);
      check_word("R9", direct_view(20'h12345));
      dir_cfg = 20'hA7E5B; tick(SETTLE);
      check_word("R8", direct_view(20'hA7E5B));
      mode_b = 1'b0; tick(SETTLE);
      check_word("R8", held);
   endtask

   initial begin
      logic [19:0] w1, w2, w3;
      w1 = 20'hA5C3E;
      w2 = 20'h5B1D7;
      w3 = {w2[15:0], 4'h9};
      t_reset();
      t_serial_primary(w1, 20'h0);
      t_serial_primary(w2, w1);
      t_serial_enh(8'hC5, w2);
      t_enh_gate(8'hC5);
      t_short_commit(w2);
      t_mode_ignore(w3);
      t_parallel(w3);
      t_direct({1'b1, 1'b1, 8'h3C, 6'h2A, 4'h6});
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule